// File: doc/BRIEF.md
# Peak-Driven Gain-Ranging Controller

This block steers the analog front end of a dual-input IF receiver so that the converter sees a signal level inside a narrow window. On every clock it reads an unsigned peak-magnitude word taken from the converter output for the channel currently routed to the shared gain stage. It then moves among six gain ranges that are 6 dB apart. The range is one state of a small state machine. From that state the block drives a three-way attenuator select, a two-way amplifier gain select and a 3-bit range code. The range code serves as the exponent that goes with the converter's mantissa.

There are two thresholds. A peak above the upper one removes 6 dB of gain. A peak below the lower one adds 6 dB back. The lower threshold sits about 12 dB under the upper one, so after a step up the signal lands about 6 dB below the point where it would switch down again. This gap keeps the range from chattering. The block also registers a channel-select input and drives the analog multiplexer select from it. Changing the channel does not move the gain range.

The six states are RNG_0 through RNG_5. RNG_0 is maximum gain: attenuator 0 dB, amplifier +18 dB, total +18 dB. Each later state removes 6 dB. RNG_5 is attenuator -24 dB, amplifier +12 dB, total -12 dB. Each state has three transitions: STEP_DOWN to the next state (less gain) when the peak is over the upper threshold, STEP_UP to the previous state (more gain) when the peak is under the lower threshold, and HOLD in all other cases. STEP_DOWN from RNG_5 and STEP_UP from RNG_0 become HOLD. A synchronous reset from any state goes to RNG_0.

Top module: `gain_range_ctrl`

## Requirements
- R1: When `rst` is high at a clock edge, the range code becomes 000, `atten_sel` becomes 00, `amp_hi` becomes 1 and `route_b` becomes 0 after that edge, whatever the other inputs are.
- R2: When `peak_mag` is strictly greater than HI_TH (default 1024) and the code is below 101, the code rises by exactly one after the edge.
- R3: When `peak_mag` is strictly less than LO_TH (default 256) and the code is above 000, the code falls by exactly one after the edge.
- R4: When LO_TH <= `peak_mag` <= HI_TH, the code does not change. This includes both boundary values.
- R5: The code saturates. Over-threshold peaks leave 101 at 101, and under-threshold peaks leave 000 at 000.
- R6: `atten_sel` is the range code shifted right by one. The encoding is 00 = 0 dB, 01 = -12 dB and 10 = -24 dB. The value 11 never appears.
- R7: `amp_hi` is 1 (+18 dB) for even codes and 0 (+12 dB) for odd codes.
- R8: The range code never takes the values 110 or 111.
- R9: `route_b` equals the `chan_sel` sampled at the previous edge (0 selects input A, 1 selects input B). A change on `chan_sel` does not change the range code.
- R10: The code moves by at most one step per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| peak_mag | input | PEAK_W (11) | Unsigned peak magnitude of the routed channel |
| chan_sel | input | 1 | Channel request: 0 = A, 1 = B |
| route_b | output | 1 | Registered analog multiplexer select |
| atten_sel | output | 2 | Attenuator step: 00 0 dB, 01 -12 dB, 10 -24 dB |
| amp_hi | output | 1 | Amplifier gain: 1 = +18 dB, 0 = +12 dB |
| range_code | output | 3 | Range indicator / exponent, 000 to 101 |

## Verification
The assertions assume that `rst` is asserted at least once before anything is checked. They are disarmed until that first reset, because the range register has no defined value before it. They also assume that `peak_mag` is a known value on every clock edge. The stimulus holds reset high from time zero and changes inputs only on falling edges, so every rising edge sees a settled peak word and channel request. The peak values are chosen on and around both thresholds and at the extremes of the word, and each one drives a single state transition.

// File: rtl/gr_pkg.sv
package gr_pkg;

    // One state per 6 dB gain range; encoding is the exported range code.
    typedef enum logic [2:0] {
        RNG_0 = 3'd0,   // +18 dB total (max gain)
        RNG_1 = 3'd1,   // +12 dB
        RNG_2 = 3'd2,   //  +6 dB
        RNG_3 = 3'd3,   //   0 dB
        RNG_4 = 3'd4,   //  -6 dB
        RNG_5 = 3'd5    // -12 dB (min gain)
    } range_e;

    typedef enum logic [1:0] {
        ATT_0DB  = 2'b00,
        ATT_12DB = 2'b01,
        ATT_24DB = 2'b10
    } atten_e;

    // Level decision produced by the comparator stage.
    typedef enum logic [1:0] {
        LVL_IN    = 2'b00,
        LVL_OVER  = 2'b01,
        LVL_UNDER = 2'b10
    } level_e;

endpackage

// File: rtl/gr_level_cmp.sv
module gr_level_cmp
    import gr_pkg::*;
#(
    parameter int PEAK_W = 11,
    parameter int HI_TH  = 1024,
    parameter int LO_TH  = 256
) (
    input  logic [PEAK_W-1:0] peak_mag,
    output level_e            level
);
    localparam logic [PEAK_W-1:0] HI_V = PEAK_W'(HI_TH);
    localparam logic [PEAK_W-1:0] LO_V = PEAK_W'(LO_TH);

    always_comb begin
        if (peak_mag > HI_V) begin
            level = LVL_OVER;
        end else if (peak_mag < LO_V) begin
            level = LVL_UNDER;
        end else begin
            level = LVL_IN;
        end
    end
endmodule

// File: rtl/gr_range_fsm.sv
module gr_range_fsm
    import gr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  level_e level,
    output range_e state
);
    range_e nxt;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RNG_0;
        end else begin
            state <= nxt;
        end
    end

    // Transitions: STEP_DOWN (over), STEP_UP (under), HOLD (otherwise)
    always_comb begin
        nxt = state;
        unique case (state)
            RNG_0: begin
                if (level == LVL_OVER)       nxt = RNG_1;
                else                         nxt = RNG_0;
            end
            RNG_1: begin
                if (level == LVL_OVER)       nxt = RNG_2;
                else if (level == LVL_UNDER) nxt = RNG_0;
                else                         nxt = RNG_1;
            end
            RNG_2: begin
                if (level == LVL_OVER)       nxt = RNG_3;
                else if (level == LVL_UNDER) nxt = RNG_1;
                else                         nxt = RNG_2;
            end
            RNG_3: begin
                if (level == LVL_OVER)       nxt = RNG_4;
                else if (level == LVL_UNDER) nxt = RNG_2;
                else                         nxt = RNG_3;
            end
            RNG_4: begin
                if (level == LVL_OVER)       nxt = RNG_5;
                else if (level == LVL_UNDER) nxt = RNG_3;
                else                         nxt = RNG_4;
            end
            RNG_5: begin
                if (level == LVL_UNDER)      nxt = RNG_4;
                else                         nxt = RNG_5;
            end
            default: nxt = RNG_0;
        endcase
    end
endmodule

// File: rtl/gr_gain_decode.sv
module gr_gain_decode
    import gr_pkg::*;
(
    input  range_e     state,
    output logic [1:0] atten_sel,
    output logic       amp_hi,
    output logic [2:0] range_code
);
    atten_e att;

    // Output process: split each 6 dB range into attenuator and amplifier steps.
    always_comb begin
        att    = ATT_0DB;
        amp_hi = 1'b1;
        unique case (state)
            RNG_0: begin att = ATT_0DB;  amp_hi = 1'b1; end
            RNG_1: begin att = ATT_0DB;  amp_hi = 1'b0; end
            RNG_2: begin att = ATT_12DB; amp_hi = 1'b1; end
            RNG_3: begin att = ATT_12DB; amp_hi = 1'b0; end
            RNG_4: begin att = ATT_24DB; amp_hi = 1'b1; end
            RNG_5: begin att = ATT_24DB; amp_hi = 1'b0; end
            default: begin att = ATT_0DB; amp_hi = 1'b1; end
        endcase
    end

    assign atten_sel  = att;
    assign range_code = state;
endmodule

// File: rtl/gain_range_ctrl.sv
module gain_range_ctrl
    import gr_pkg::*;
#(
    parameter int PEAK_W = 11,
    parameter int HI_TH  = 1024,
    parameter int LO_TH  = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PEAK_W-1:0] peak_mag,
    input  logic              chan_sel,
    output logic              route_b,
    output logic [1:0]        atten_sel,
    output logic              amp_hi,
    output logic [2:0]        range_code
);
    level_e level;
    range_e state;

    gr_level_cmp #(
        .PEAK_W (PEAK_W),
        .HI_TH  (HI_TH),
        .LO_TH  (LO_TH)
    ) u_cmp (
        .peak_mag (peak_mag),
        .level    (level)
    );

    gr_range_fsm u_fsm (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .state (state)
    );

    gr_gain_decode u_dec (
        .state      (state),
        .atten_sel  (atten_sel),
        .amp_hi     (amp_hi),
        .range_code (range_code)
    );

    // Channel routing register, independent of the range decision.
    always_ff @(posedge clk) begin
        if (rst) begin
            route_b <= 1'b0;
        end else begin
            route_b <= chan_sel;
        end
    end
endmodule

// File: rtl/gr_checker.sv
module gr_checker #(
    parameter int PEAK_W = 11,
    parameter int HI_TH  = 1024,
    parameter int LO_TH  = 256
) (
    input logic              clk,
    input logic              rst,
    input logic [PEAK_W-1:0] peak_mag,
    input logic              chan_sel,
    input logic              route_b,
    input logic [1:0]        atten_sel,
    input logic              amp_hi,
    input logic [2:0]        range_code
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b1;
    end

    logic over, under;
    assign over  = peak_mag > PEAK_W'(HI_TH);
    assign under = peak_mag < PEAK_W'(LO_TH);

    assert_reset_max_R1: assert property (@(posedge clk)
        rst |=> (range_code == 3'd0 && atten_sel == 2'b00 && amp_hi && !route_b));

    assert_step_down_R2: assert property (@(posedge clk) disable iff (rst || !armed)
        (over && range_code < 3'd5) |=> range_code == $past(range_code) + 3'd1);

    assert_step_up_R3: assert property (@(posedge clk) disable iff (rst || !armed)
        (under && range_code > 3'd0) |=> range_code == $past(range_code) - 3'd1);

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst || !armed)
        (!over && !under) |=> $stable(range_code));

    assert_sat_top_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (over && range_code == 3'd5) |=> range_code == 3'd5);

    assert_sat_bottom_R5: assert property (@(posedge clk) disable iff (rst || !armed)
        (under && range_code == 3'd0) |=> range_code == 3'd0);

    assert_atten_map_R6: assert property (@(posedge clk) disable iff (rst || !armed)
        atten_sel == range_code[2:1] && atten_sel != 2'b11);

    assert_amp_map_R7: assert property (@(posedge clk) disable iff (rst || !armed)
        amp_hi == !range_code[0]);

    assert_code_legal_R8: assert property (@(posedge clk) disable iff (rst || !armed)
        range_code <= 3'd5);

    assert_route_R9: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> route_b == $past(chan_sel));

    assert_one_step_R10: assert property (@(posedge clk) disable iff (rst || !armed)
        1'b1 |=> ($stable(range_code) || range_code == $past(range_code) + 3'd1
                  || range_code == $past(range_code) - 3'd1));
endmodule

bind gain_range_ctrl gr_checker #(
    .PEAK_W (PEAK_W),
    .HI_TH  (HI_TH),
    .LO_TH  (LO_TH)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .peak_mag   (peak_mag),
    .chan_sel   (chan_sel),
    .route_b    (route_b),
    .atten_sel  (atten_sel),
    .amp_hi     (amp_hi),
    .range_code (range_code)
);

// File: tb/tb_gain_range_ctrl.sv
`timescale 1ns/1ps
module tb_gain_range_ctrl;
    localparam int PEAK_W = 11;
    localparam int NVEC   = 19;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PEAK_W-1:0] peak_mag = '0;
    logic              chan_sel = 1'b0;
    logic              route_b;
    logic [1:0]        atten_sel;
    logic              amp_hi;
    logic [2:0]        range_code;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    gain_range_ctrl dut (
        .clk        (clk),
        .rst        (rst),
        .peak_mag   (peak_mag),
        .chan_sel   (chan_sel),
        .route_b    (route_b),
        .atten_sel  (atten_sel),
        .amp_hi     (amp_hi),
        .range_code (range_code)
    );

    // {peak, chan, expected code after the edge}; HI_TH=1024, LO_TH=256
    localparam logic [14:0] VEC [NVEC] = '{
        {11'd300,  1'b0, 3'd0},   // R4 hold in window
        {11'd100,  1'b0, 3'd0},   // R5 floor saturation
        {11'd1500, 1'b0, 3'd1},   // R2
        {11'd1025, 1'b1, 3'd2},   // R2 just over, R9 chan B
        {11'd1024, 1'b1, 3'd2},   // R4 upper boundary
        {11'd2047, 1'b0, 3'd3},   // R2
        {11'd2000, 1'b0, 3'd4},
        {11'd2000, 1'b0, 3'd5},
        {11'd2047, 1'b0, 3'd5},   // R5 ceiling
        {11'd256,  1'b0, 3'd5},   // R4 lower boundary
        {11'd255,  1'b1, 3'd4},   // R3 just under
        {11'd500,  1'b1, 3'd4},
        {11'd0,    1'b1, 3'd3},   // R3
        {11'd10,   1'b0, 3'd2},
        {11'd1100, 1'b0, 3'd3},
        {11'd5,    1'b0, 3'd2},
        {11'd5,    1'b0, 3'd1},
        {11'd5,    1'b0, 3'd0},
        {11'd5,    1'b0, 3'd0}    // R5 floor
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Outputs expected from a code, per R6/R7/R8
    task automatic check_outputs(input logic [2:0] code);
        check("R6 atten_sel", int'(atten_sel), int'(code >> 1));
        check("R7 amp_hi", int'(amp_hi), (code[0] == 1'b0) ? 1 : 0);
        check("R8 code legal", int'(range_code <= 3'd5), 1);
    endtask

    task automatic step(input logic [PEAK_W-1:0] p, input logic c);
        peak_mag = p;
        chan_sel = c;
        @(posedge clk);
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected<5000 cycles", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 code", int'(range_code), 0);
        check("R1 route", int'(route_b), 0);
        check_outputs(3'd0);
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            logic [2:0] prev;
            prev = range_code;
            step(VEC[i][14:4], VEC[i][3]);
            check("R2/R3/R4/R5 code", int'(range_code), int'(VEC[i][2:0]));
            check("R9 route", int'(route_b), int'(VEC[i][3]));
            check("R10 one step", int'((range_code == prev) || (range_code == prev + 3'd1)
                                       || (range_code == prev - 3'd1)), 1);
            check_outputs(VEC[i][2:0]);
        end

        // R9: channel change alone leaves range unchanged
        step(11'd600, 1'b0);
        step(11'd600, 1'b1);
        check("R9 range kept", int'(range_code), 0);
        check("R9 route B", int'(route_b), 1);

        // R1: mid-run reset with an over-threshold peak
        step(11'd2047, 1'b1);
        step(11'd2047, 1'b1);
        step(11'd2047, 1'b1);
        check("R2 climb", int'(range_code), 3);
        rst = 1'b1;
        step(11'd2047, 1'b1);
        check("R1 reset code", int'(range_code), 0);
        check("R1 reset route", int'(route_b), 0);
        check_outputs(3'd0);
        rst = 1'b0;
        step(11'd2047, 1'b0);
        check("R2 after reset", int'(range_code), 1);
        check_outputs(3'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule